// File: doc/BRIEF.md
# External Sync Trigger Gate

This block sits between a link-side sample stream and the application side, in the device clock domain. Software can arm it with a single-cycle request. Once armed, the gate drops the valid qualifier, zeroes the data it passes on, and holds a reset line to downstream processing. It stays that way until the external synchronization input shows a rising edge. From the cycle after that edge, samples flow again, and the downstream logic starts from a clean state.

Software can cancel a pending wait without any trigger. A manual request produces a one-cycle pulse that the surrounding fabric can route back to the sync input, so the release can be generated internally. A build-time parameter removes all of this. With it cleared, the gate is a plain wire: it never arms and it never emits the manual pulse. All control inputs arrive as one-cycle pulses that are already in the device clock domain.

Top module: `sync_trigger_gate`

## Requirements
- R1: An arm pulse (`arm_req`=1) sets `waiting` to 1 at the next rising clock edge, and `waiting` stays 1 until it is released.
- R2: While waiting, a rising edge of `ext_sync` clears `waiting`. The edge is 0 in the previous cycle and 1 in this cycle. A level that stays high, or a falling edge, does not clear it.
- R3: A rising edge of `ext_sync` in the same cycle as an arm pulse is ignored, and the gate stays waiting.
- R4: `downstream_rst` equals `waiting` in every cycle.
- R5: A disarm pulse clears `waiting` at the next edge. When arm and disarm come in the same cycle, disarm wins.
- R6: While waiting, `out_valid`=0 and `out_data`=0. Otherwise `out_valid`=`in_valid` and `out_data`=`in_data` in the same cycle, with no register on the path.
- R7: A manual pulse makes `manual_sync` 1 for exactly the next cycle. It does not change `waiting` by itself.
- R8: With `EXT_SYNC_EN`=0, `waiting`, `downstream_rst` and `manual_sync` stay 0 whatever the control inputs do, and data always passes.
- R9: During and right after reset, `waiting`=0 and `manual_sync`=0. The stored copy of `ext_sync` reads 0, so `ext_sync` high in the first cycle counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_req | input | 1 | One-cycle request to wait for the trigger |
| disarm_req | input | 1 | One-cycle request to cancel the wait |
| manual_req | input | 1 | One-cycle request to emit a sync pulse |
| ext_sync | input | 1 | External trigger, synchronous to clk |
| in_valid | input | 1 | Link-side sample qualifier |
| in_data | input | DATA_W | Link-side samples |
| out_valid | output | 1 | Gated qualifier |
| out_data | output | DATA_W | Gated samples |
| waiting | output | 1 | High while armed and the trigger has not arrived |
| downstream_rst | output | 1 | Reset to application logic |
| manual_sync | output | 1 | Self-generated sync pulse |

## Verification
The bench drives inputs just after a falling edge and samples in the next low phase. Arm, disarm and trigger effects are due one rising edge after the stimulus cycle. A manual request shows on `manual_sync` one edge later and is gone one edge after that. The `out_valid`/`out_data` gating uses no register, so each check compares against the `waiting` value that was just updated and the inputs still applied. A second instance with the feature disabled sees the same stimulus and is checked every step for pass-through.

// File: rtl/sync_trigger_gate.sv
module sync_trigger_gate #(
  parameter int DATA_W      = 64,
  parameter bit EXT_SYNC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic              disarm_req,
  input  logic              manual_req,
  input  logic              ext_sync,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              waiting,
  output logic              downstream_rst,
  output logic              manual_sync
);

  logic sync_q;
  logic armed_q;
  logic man_q;
  logic trig;

  assign trig = ext_sync & ~sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      armed_q <= 1'b0;
      man_q   <= 1'b0;
    end else begin
      sync_q <= ext_sync;
      man_q  <= EXT_SYNC_EN & manual_req;
      if (!EXT_SYNC_EN || disarm_req)
        armed_q <= 1'b0;
      else if (arm_req)
        armed_q <= 1'b1;
      else if (trig)
        armed_q <= 1'b0;
    end
  end

  assign waiting        = armed_q;
  assign downstream_rst = armed_q;
  assign manual_sync    = man_q;
  assign out_valid      = in_valid & ~armed_q;
  assign out_data       = armed_q ? '0 : in_data;

  p_arm_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && arm_req && !disarm_req) |=> waiting);

  p_rise_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(arm_req));

  p_edge_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !arm_req && ext_sync && !$past(ext_sync)) |=> !waiting);

  p_level_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !disarm_req && (!ext_sync || $past(ext_sync))) |=> waiting);

  p_rst_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    downstream_rst == waiting);

  p_disarm_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_req |=> !waiting);

  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!out_valid && out_data == '0));

  p_manual_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_SYNC_EN && manual_req) |=> manual_sync);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !EXT_SYNC_EN |-> (!waiting && !manual_sync && out_valid == in_valid));

endmodule

// File: tb/sim_sync_trigger_gate.sv
module sim_sync_trigger_gate;
  localparam int DW = 16;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 0, dis = 0, man = 0, sy = 0, vld = 0;
  logic [DW-1:0] din = '0;
  logic ov0, w0, dr0, m0, ov1, w1, dr1, m1;
  logic [DW-1:0] od0, od1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_trigger_gate #(.DATA_W(DW), .EXT_SYNC_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_req(arm), .disarm_req(dis), .manual_req(man),
    .ext_sync(sy), .in_valid(vld), .in_data(din), .out_valid(ov0), .out_data(od0),
    .waiting(w0), .downstream_rst(dr0), .manual_sync(m0));

  sync_trigger_gate #(.DATA_W(DW), .EXT_SYNC_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .arm_req(arm), .disarm_req(dis), .manual_req(man),
    .ext_sync(sy), .in_valid(vld), .in_data(din), .out_valid(ov1), .out_data(od1),
    .waiting(w1), .downstream_rst(dr1), .manual_sync(m1));

  // {arm, disarm, manual, sync, valid, data[15:0], exp_waiting, exp_valid, exp_manual}
  localparam logic [23:0] VEC [NV] = '{
    {5'b00001, 16'h1111, 3'b010},  // idle pass R6
    {5'b10001, 16'h2222, 3'b100},  // arm R1
    {5'b00001, 16'h3333, 3'b100},  // hold R1
    {5'b00011, 16'h4444, 3'b010},  // rising edge R2
    {5'b00011, 16'h5555, 3'b010},  // level high, flowing
    {5'b10011, 16'h6666, 3'b100},  // arm while high, no edge R1
    {5'b00011, 16'h7777, 3'b100},  // level high keeps waiting R2
    {5'b00001, 16'h8888, 3'b100},  // falling edge keeps waiting R2
    {5'b01001, 16'h9999, 3'b010},  // disarm R5
    {5'b11001, 16'hAAAA, 3'b010},  // arm+disarm -> disarm wins R5
    {5'b10011, 16'hBBBB, 3'b100},  // edge with arm ignored R3
    {5'b00011, 16'hCCCC, 3'b100},  // still waiting R3
    {5'b00001, 16'hDDDD, 3'b100},
    {5'b00101, 16'hEEEE, 3'b101},  // manual pulse next cycle R7
    {5'b00001, 16'hF0F0, 3'b100},  // pulse gone, still waiting R7
    {5'b00011, 16'h0F0F, 3'b010},  // release R2
    {5'b00010, 16'h1234, 3'b000},  // invalid passes as invalid R6
    {5'b10001, 16'h4321, 3'b100}   // re-arm R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic d, input logic m, input logic s, input logic v, input logic [DW-1:0] x);
    arm = a; dis = d; man = m; sy = s; vld = v; din = x;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 waiting in reset", {31'd0, w0}, 0);
    chk("R9 manual in reset", {31'd0, m0}, 0);
    chk("R4 rst in reset", {31'd0, dr0}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      logic [DW-1:0] ed;
      v = VEC[i];
      drive(v[23], v[22], v[21], v[20], v[19], v[18:3]);
      @(negedge clk);
      ed = v[2] ? '0 : v[18:3];
      chk($sformatf("R1/R2/R3/R5 waiting step %0d", i), {31'd0, w0}, {31'd0, v[2]});
      chk($sformatf("R4 step %0d", i), {31'd0, dr0}, {31'd0, v[2]});
      chk($sformatf("R6 valid step %0d", i), {31'd0, ov0}, {31'd0, v[1]});
      chk($sformatf("R6 data step %0d", i), {16'd0, od0}, {16'd0, ed});
      chk($sformatf("R7 manual step %0d", i), {31'd0, m0}, {31'd0, v[0]});
      chk($sformatf("R8 waiting step %0d", i), {29'd0, w1, dr1, m1}, 0);
      chk($sformatf("R8 data step %0d", i), {15'd0, ov1, od1}, {15'd0, v[19], v[18:3]});
    end

    // R9: reset while waiting, then ext_sync high in first cycle counts as an edge
    drive(0, 0, 0, 1, 1, 16'hABCD);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears waiting", {31'd0, w0}, 0);
    drive(1, 0, 0, 1, 1, 16'hABCD);
    @(negedge clk);
    chk("R9 arm in reset ignored", {31'd0, w0}, 0);
    rst_n = 1'b1;
    drive(1, 0, 0, 0, 1, 16'h0001);
    @(negedge clk);
    chk("R1 armed after reset", {31'd0, w0}, 1);
    drive(0, 0, 0, 1, 1, 16'h0002);
    @(negedge clk);
    chk("R2 first edge after arm releases", {31'd0, w0}, 0);
    chk("R6 data flows", {15'd0, ov0, od0}, {15'd0, 1'b1, 16'h0002});

    // R7 loopback: manual pulse routed to ext_sync releases the gate
    drive(1, 0, 0, 0, 1, 16'h0003);
    @(negedge clk);
    drive(0, 0, 1, 0, 1, 16'h0004);
    @(negedge clk);
    chk("R7 manual no release", {31'd0, w0}, 1);
    drive(0, 0, 0, m0, 1, 16'h0005);
    @(negedge clk);
    chk("R7 looped pulse releases", {31'd0, w0}, 0);
    chk("R7 pulse one cycle", {31'd0, m0}, 0);

    // R8 disabled instance ignores manual
    chk("R8 disabled manual", {31'd0, m1}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule